// File: doc/BRIEF.md
# Extended Control Field Shadow Latch

This block guards the extended control bits that sit in four control registers of a serial port. An extension-enable flag decides whether those bits are live. While the flag is clear, the guarded bits read back as zero, which keeps legacy software working. The values software last programmed are kept in a shadow store. When the flag is set again, the kept values come back.

Software reaches the block through two plain write ports. One writes a whole register in a chosen slot. The other writes the extension-enable flag. The rest of the serial port reads the effective fields of all four slots on one flat bus. Software readback of one chosen slot is combinational.

Slot mapping and guarded bits (the masks):
- slot 0 is interrupt enable, guarded bits 7:4 (mask 8'hF0)
- slot 1 is interrupt identification, guarded bits 5:4 (mask 8'h30)
- slot 2 is FIFO control, guarded bits 5:4 (mask 8'h30)
- slot 3 is modem control, guarded bits 7:5 (mask 8'hE0)

Slot s occupies bits [8s+7:8s] of `fields_o`.

Top module: `xshadow_latch`

## Requirements
- R1: After reset, `xen_o` is 0, every bit of `fields_o` is 0, and the shadow store is zero.
- R2: A register write updates the unguarded bits of the selected slot from `reg_wdata`. The new value is visible on the cycle after the write, whatever the state of the flag.
- R3: While `xen_o` is 1, a register write also updates the guarded bits of the selected slot, so the whole byte takes `reg_wdata`.
- R4: While `xen_o` is 0, the guarded bits of every slot read 0, and a register write leaves them unchanged.
- R5: Writing the flag to 0 while it is 1 does two things. It copies the guarded bits of every slot into the shadow store, and on the next cycle it makes those bits 0.
- R6: Writing the flag to 1 while it is 0 reloads the guarded bits of every slot from the shadow store, visible on the next cycle.
- R7: Writing the flag with the value it already holds changes neither the fields nor the shadow store.
- R8: A register write in the same cycle as a flag change is handled as follows:
  - On a change from 1 to 0, the written byte is accepted in full and its guarded bits are what gets saved.
  - On a change from 0 to 1, the guarded bits of the write are dropped and the restored values win. The unguarded bits land either way.
- R9: `rd_data` equals the effective byte of the slot selected by `rd_sel`, combinationally.
- R10: `xen_o` takes the value of `xen_wdata` on the cycle after each flag write, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Slot selected by the write |
| reg_wdata | input | 8 | Byte to write |
| xen_wr | input | 1 | Extension-enable flag write strobe |
| xen_wdata | input | 1 | New flag value |
| xen_o | output | 1 | Current extension-enable flag |
| fields_o | output | 32 | Effective bytes of all slots, slot s at [8s+7:8s] |
| rd_sel | input | 2 | Slot chosen for readback |
| rd_data | output | 8 | Effective byte of the chosen slot |

## Verification
A register write and a flag change can land on the same clock edge. The outcome then depends on an ordering rule: the write is merged first under the old flag, and the save or restore is applied after that. The bench provokes both orderings with directed cycles that assert `reg_wr` and `xen_wr` together, once with the flag falling and once with it rising. A later flag toggle then brings the shadow contents out through the fields. A behavioural model that applies the stated rule is compared against every output on every clock, and a random phase adds further collisions.

// File: rtl/xshadow_pkg.sv
package xshadow_pkg;

  // Action taken on the guarded bits when the enable flag is written
  typedef enum logic [1:0] {
    XACT_NONE    = 2'd0,
    XACT_SAVE    = 2'd1,
    XACT_RESTORE = 2'd2
  } xact_e;

  localparam int unsigned XSH_DATA_W = 8;
  localparam int unsigned XSH_SLOTS  = 4;

  // Guarded bits per slot, slot 0 in the low byte
  localparam logic [XSH_SLOTS*XSH_DATA_W-1:0] XSH_DEFAULT_MASK = 32'hE0_30_30_F0;

endpackage

// File: rtl/xsh_enable_ctl.sv
module xsh_enable_ctl
  import xshadow_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_wr,
  input  logic  en_val,
  output logic  xen_q,
  output xact_e act
);

  // Only a real transition of the flag saves or restores
  always_comb begin
    act = XACT_NONE;
    if (en_wr && xen_q && !en_val)      act = XACT_SAVE;
    else if (en_wr && !xen_q && en_val) act = XACT_RESTORE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     xen_q <= 1'b0;
    else if (en_wr) xen_q <= en_val;
  end

  assert_same_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && (en_val == xen_q)) |-> (act == XACT_NONE));

  assert_flag_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (xen_q == $past(en_val)));

  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(xen_q));

endmodule

// File: rtl/xsh_slot.sv
module xsh_slot
  import xshadow_pkg::*;
#(
  parameter int unsigned       DATA_W = 8,
  parameter logic [DATA_W-1:0] MASK   = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xen_q,
  input  xact_e             act,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] eff
);

  localparam logic [DATA_W-1:0] OPEN = ~MASK;

  logic [DATA_W-1:0] live_q;
  logic [DATA_W-1:0] shadow_q;
  logic [DATA_W-1:0] merged;

  // Write merge under the flag value held before this edge
  always_comb begin
    merged = live_q;
    if (wr_hit) begin
      if (xen_q) merged = wr_data;
      else       merged = (live_q & MASK) | (wr_data & OPEN);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q   <= '0;
      shadow_q <= '0;
    end else begin
      unique case (act)
        XACT_SAVE: begin
          shadow_q <= merged & MASK;
          live_q   <= merged & OPEN;
        end
        XACT_RESTORE: live_q <= (merged & OPEN) | shadow_q;
        default:      live_q <= merged;
      endcase
    end
  end

  assign eff = live_q;

  assert_locked_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !xen_q |-> ((eff & MASK) == '0));

  assert_open_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((eff & OPEN) == ($past(wr_data) & OPEN)));

  assert_full_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && xen_q && act == XACT_NONE) |=> (eff == $past(wr_data)));

  assert_save_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act == XACT_SAVE) |=> ((eff & MASK) == '0));

  assert_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act == XACT_RESTORE) |=> ((eff & MASK) == $past(shadow_q)));

  assert_shadow_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act != XACT_SAVE) |=> $stable(shadow_q));

endmodule

// File: rtl/xsh_readmux.sv
module xsh_readmux #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned SEL_W  = 2
) (
  input  logic [SLOTS*DATA_W-1:0] fields,
  input  logic [SEL_W-1:0]        sel,
  output logic [DATA_W-1:0]       data
);

  always_comb begin
    data = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (sel == SEL_W'(i)) data = fields[i*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/xshadow_latch.sv
module xshadow_latch
  import xshadow_pkg::*;
#(
  parameter int unsigned                   DATA_W    = XSH_DATA_W,
  parameter int unsigned                   NUM_REGS  = XSH_SLOTS,
  parameter logic [NUM_REGS*DATA_W-1:0]    PROT_MASK = XSH_DEFAULT_MASK,
  localparam int unsigned                  SEL_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [SEL_W-1:0]           reg_sel,
  input  logic [DATA_W-1:0]          reg_wdata,
  input  logic                       xen_wr,
  input  logic                       xen_wdata,
  output logic                       xen_o,
  output logic [NUM_REGS*DATA_W-1:0] fields_o,
  input  logic [SEL_W-1:0]           rd_sel,
  output logic [DATA_W-1:0]          rd_data
);

  logic  xen_q;
  xact_e act;

  xsh_enable_ctl u_enable (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_wr  (xen_wr),
    .en_val (xen_wdata),
    .xen_q  (xen_q),
    .act    (act)
  );

  for (genvar s = 0; s < NUM_REGS; s++) begin : g_slot
    localparam logic [SEL_W-1:0] SLOT_ID = SEL_W'(s);
    logic hit;
    assign hit = reg_wr && (reg_sel == SLOT_ID);

    xsh_slot #(
      .DATA_W (DATA_W),
      .MASK   (PROT_MASK[s*DATA_W +: DATA_W])
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .xen_q   (xen_q),
      .act     (act),
      .wr_hit  (hit),
      .wr_data (reg_wdata),
      .eff     (fields_o[s*DATA_W +: DATA_W])
    );
  end

  xsh_readmux #(
    .DATA_W (DATA_W),
    .SLOTS  (NUM_REGS),
    .SEL_W  (SEL_W)
  ) u_rd (
    .fields (fields_o),
    .sel    (rd_sel),
    .data   (rd_data)
  );

  assign xen_o = xen_q;

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (!xen_o && fields_o == '0));

  assert_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data == fields_o[rd_sel*DATA_W +: DATA_W]);

endmodule

// File: tb/xshadow_latch_tb.sv
`timescale 1ns/100ps
module xshadow_latch_tb;

  localparam bit [7:0] MASKS [4] = '{8'hF0, 8'h30, 8'h30, 8'hE0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic        xen_wr = 1'b0;
  logic        xen_wdata = 1'b0;
  logic        xen_o;
  logic [31:0] fields_o;
  logic [1:0]  rd_sel = '0;
  logic [7:0]  rd_data;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;
  string tag = "R1";

  // behavioural reference state
  bit [7:0] m_live [4];
  bit [7:0] m_shadow [4];
  bit       m_xen;

  always #2.5 clk = ~clk;

  xshadow_latch u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .xen_wr(xen_wr), .xen_wdata(xen_wdata),
    .xen_o(xen_o), .fields_o(fields_o), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit [31:0] model_fields();
    bit [31:0] f;
    for (int s = 0; s < 4; s++) f[s*8 +: 8] = m_live[s];
    return f;
  endfunction

  // Write first under the old flag, then save/restore on a flag transition
  task automatic model_step();
    for (int s = 0; s < 4; s++) begin
      bit [7:0] nl = m_live[s];
      if (reg_wr && reg_sel == 2'(s))
        nl = m_xen ? reg_wdata : ((nl & MASKS[s]) | (reg_wdata & ~MASKS[s]));
      if (xen_wr && m_xen && !xen_wdata) begin
        m_shadow[s] = nl & MASKS[s];
        nl = nl & ~MASKS[s];
      end else if (xen_wr && !m_xen && xen_wdata) begin
        nl = (nl & ~MASKS[s]) | m_shadow[s];
      end
      m_live[s] = nl;
    end
    if (xen_wr) m_xen = xen_wdata;
  endtask

  task automatic compare_all();
    check("fields", fields_o, model_fields());
    check("flag", {31'd0, xen_o}, {31'd0, m_xen});
    check("readback", {24'd0, rd_data}, {24'd0, m_live[rd_sel]});
  endtask

  // one clock: inputs already driven, update model at the edge, compare after it
  task automatic cyc(bit w, bit [1:0] sel, bit [7:0] d, bit ew, bit ev, bit [1:0] rs);
    reg_wr = w; reg_sel = sel; reg_wdata = d;
    xen_wr = ew; xen_wdata = ev; rd_sel = rs;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(bit [1:0] rs);
    cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, rs);
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin m_live[s] = '0; m_shadow[s] = '0; end
    m_xen = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    tag = "R1";
    check("reset fields", fields_o, 32'h0);
    check("reset flag", {31'd0, xen_o}, 32'd0);
    rst_n = 1'b1;
    idle(2'd0);

    // R2 and R4: flag clear, guarded bits dropped, open bits land
    tag = "R4";
    for (int s = 0; s < 4; s++) cyc(1'b1, 2'(s), 8'hFF, 1'b0, 1'b0, 2'(s));
    tag = "R2";
    check("open bits", fields_o, 32'h1F_CF_CF_0F);

    // R6: first enable restores the zero shadow
    tag = "R6";
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 2'd0);
    // R10: flag follows the write
    tag = "R10";
    check("flag set", {31'd0, xen_o}, 32'd1);

    // R3: full bytes land while enabled
    tag = "R3";
    cyc(1'b1, 2'd0, 8'hA5, 1'b0, 1'b0, 2'd0);
    cyc(1'b1, 2'd1, 8'h3C, 1'b0, 1'b0, 2'd1);
    cyc(1'b1, 2'd2, 8'h96, 1'b0, 1'b0, 2'd2);
    cyc(1'b1, 2'd3, 8'hE7, 1'b0, 1'b0, 2'd3);
    check("full bytes", fields_o, 32'hE7_96_3C_A5);

    // R5: disable saves and clears
    tag = "R5";
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 2'd0);
    check("cleared", fields_o, 32'hE7_96_3C_A5 & ~32'hE0_30_30_F0);

    // R7: writing 0 again does not overwrite the shadow
    tag = "R7";
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 2'd0);
    // R4: guarded bits ignored while disabled
    tag = "R4";
    cyc(1'b1, 2'd3, 8'h1F, 1'b0, 1'b0, 2'd3);
    cyc(1'b1, 2'd3, 8'hFF, 1'b0, 1'b0, 2'd3);

    // R6: restore brings back saved values
    tag = "R6";
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 2'd3);
    check("restored slot0", {24'd0, fields_o[7:0]}, 32'hA5);

    // R7: writing 1 again after an edit keeps the edit
    tag = "R7";
    cyc(1'b1, 2'd0, 8'h5A, 1'b0, 1'b0, 2'd0);
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 2'd0);
    check("edit kept", {24'd0, rd_data}, 32'h5A);

    // R8: write and falling flag on one edge, written byte is saved
    tag = "R8";
    cyc(1'b1, 2'd1, 8'hF3, 1'b1, 1'b0, 2'd1);
    check("fall collide", {24'd0, rd_data}, 32'hC3);
    // R8: write and rising flag on one edge, restore wins on guarded bits
    cyc(1'b1, 2'd1, 8'h0A, 1'b1, 1'b1, 2'd1);
    check("rise collide", {24'd0, rd_data}, 32'h3A);

    // R9: sweep readback
    tag = "R9";
    for (int s = 0; s < 4; s++) idle(2'(s));

    // mixed random traffic, collisions included
    tag = "R8";
    for (int i = 0; i < 400; i++)
      cyc(1'($urandom), 2'($urandom), 8'($urandom),
          ($urandom % 4) == 0, 1'($urandom), 2'($urandom));

    // R1: reset again in the middle of traffic
    tag = "R1";
    rst_n = 1'b0;
    @(posedge clk);
    for (int s = 0; s < 4; s++) begin m_live[s] = '0; m_shadow[s] = '0; end
    m_xen = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    compare_all();
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 2'd0);
    check("shadow zero after reset", fields_o, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule